// File: doc/BRIEF.md
# Shared-Line Converter Word Reader

This controller sits on the host side of a delta-sigma converter whose single output pin is used twice: first to announce that a conversion is ready, then to carry that conversion's bits. The reader watches the line and qualifies a ready announcement. It then drives a serial clock that idles low and shifts in a 24-bit two's-complement word, most significant bit first. Each finished word is handed on with a one-cycle strobe and the index of the channel it was measured on.

The reader also drives a two-bit channel-select output. In scan mode it steps through the four channels by itself, one step per delivered word, and wraps from 3 back to 0. In fixed mode it follows a host-supplied channel number. A conversion that was in progress when the select lines moved is still clocked out, but it is thrown away. A deadline timer makes sure a read that has not finished before the converter's next ready window is cut short and flagged.

States: `ST_IDLE` (listening) goes to `ST_GAP` on a qualified ready. `ST_GAP` waits the start gap and goes to `ST_CLK_LO`. `ST_CLK_LO` goes to `ST_CLK_HI` after a low half-period, and the rising edge samples one bit there. `ST_CLK_HI` goes back to `ST_CLK_LO`, or to `ST_FINISH` once all bits are in. `ST_GAP`, `ST_CLK_LO` and `ST_CLK_HI` go to `ST_EXPIRE` when the deadline is reached. `ST_FINISH` and `ST_EXPIRE` step the channel and return to `ST_IDLE`.

Top module: `srd_reader`

## Requirements
- R1: A ready indication is the synchronized line held high for at least HI_MIN (default 8) consecutive cycles and then seen low. A shorter high run is ignored. No serial clock pulse is issued after reset until the first qualified ready.
- R2: After a ready, the reader waits START_GAP cycles and then issues exactly WORD_W (24) serial clock pulses. Each pulse is low for HALF_DIV cycles and then high for HALF_DIV cycles. `sclk` stays low at all other times.
- R3: A bit is sampled on every rising edge of `sclk`. The first sampled bit ends up in `word_data[23]` and the last in `word_data[0]`.
- R4: Received codes are passed through unchanged as two's complement with bit 23 as the sign. This holds for 7FFFFF (positive full scale), 000000 (zero) and 800000 (negative full scale).
- R5: A completed word raises `word_valid` for exactly one cycle, with `word_late` low and `sclk` low in that cycle.
- R6: If a read has not taken in all bits within DEADLINE cycles of the ready, it is aborted and `sclk` returns low. `word_valid` then pulses with `word_late` high and `word_data` equal to 0.
- R7: `word_chan` during the strobe equals the channel selected while that conversion was made.
- R8: In scan mode (`scan_en`=1), `chsel` advances by one modulo 4 after each delivered word. It is unchanged at all other times.
- R9: In fixed mode (`scan_en`=0), `chsel` takes the value of `chan_in` at the end of each read, and only then.
- R10: The read that directly follows a change of `chsel` is still clocked out in full (24 pulses) but produces no strobe.
- R11: After reset, `sclk`, `word_valid` and `word_late` are 0 and `chsel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Shared ready/data line from the converter |
| scan_en | input | 1 | 1: automatic channel scan, 0: follow `chan_in` |
| chan_in | input | 2 | Requested channel in fixed mode |
| sclk | output | 1 | Serial shift clock to the converter, idles low |
| chsel | output | 2 | Channel-select lines to the converter |
| word_valid | output | 1 | One-cycle strobe for a delivered word |
| word_late | output | 1 | With the strobe: the read missed its deadline |
| word_data | output | 24 | Received conversion word, two's complement |
| word_chan | output | 2 | Channel the delivered word belongs to |

## Verification
The checker watches several rules on every cycle. No clock pulse may come before the first qualified ready. A read may never issue more than 24 pulses. The strobe must never coincide with a high clock. An aborted word must read as zero. The channel select may move only at the end of a read, and in scan mode it must move by exactly one after a delivered word. Other behaviours need the converter model in the bench: whether the bits land in the right order, whether the boundary codes pass unchanged, the tag carried by each word, which read after a channel change is dropped, and whether a read that is too slow is flagged.

// File: rtl/srd_pkg.sv
package srd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_GAP    = 3'd1,
        ST_CLK_LO = 3'd2,
        ST_CLK_HI = 3'd3,
        ST_FINISH = 3'd4,
        ST_EXPIRE = 3'd5
    } srd_state_e;

endpackage

// File: rtl/srd_line_front.sv
module srd_line_front #(
    parameter int SYNC_STAGES = 2,
    parameter int HI_MIN      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic listen,
    output logic line_s,
    output logic rdy_evt
);
    localparam int HCW = $clog2(HI_MIN + 1);
    localparam logic [HCW-1:0] HI_TOP = HCW'(HI_MIN);

    logic [HCW-1:0] hi_cnt_q;

    generate
        if (SYNC_STAGES < 2) begin : g_single
            logic sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= 1'b0;
                else        sync_q <= line_in;
            end
            assign line_s = sync_q;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            end
            assign line_s = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    // Run length of the high level, counted only while listening.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else if (!listen || !line_s) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q != HI_TOP) begin
            hi_cnt_q <= hi_cnt_q + HCW'(1);
        end
    end

    assign rdy_evt = listen && !line_s && (hi_cnt_q == HI_TOP);

endmodule

// File: rtl/srd_shifter.sv
module srd_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clear) begin
            sh_q <= '0;
        end else if (shift_en) begin
            sh_q <= {sh_q[WORD_W-2:0], bit_in};
        end
    end

    assign word = sh_q;

endmodule

// File: rtl/srd_chan_step.sv
module srd_chan_step #(
    parameter int CHAN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              scan_en,
    input  logic [CHAN_W-1:0] chan_in,
    output logic [CHAN_W-1:0] chsel,
    output logic              skip
);
    logic [CHAN_W-1:0] chsel_q;
    logic [CHAN_W-1:0] next_c;
    logic              skip_q;

    // A dropped read does not advance the scan; it only clears the drop flag.
    always_comb begin
        if (scan_en) next_c = skip_q ? chsel_q : chsel_q + CHAN_W'(1);
        else         next_c = chan_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chsel_q <= '0;
            skip_q  <= 1'b0;
        end else if (step) begin
            chsel_q <= next_c;
            skip_q  <= (next_c != chsel_q);
        end
    end

    assign chsel = chsel_q;
    assign skip  = skip_q;

endmodule

// File: rtl/srd_reader.sv
module srd_reader
    import srd_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int CHAN_W      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int HI_MIN      = 8,
    parameter int START_GAP   = 4,
    parameter int HALF_DIV    = 4,
    parameter int DEADLINE    = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic              scan_en,
    input  logic [CHAN_W-1:0] chan_in,
    output logic              sclk,
    output logic [CHAN_W-1:0] chsel,
    output logic              word_valid,
    output logic              word_late,
    output logic [WORD_W-1:0] word_data,
    output logic [CHAN_W-1:0] word_chan
);
    localparam int DIV_MAX = (START_GAP > HALF_DIV) ? START_GAP : HALF_DIV;
    localparam int DIVW    = $clog2(DIV_MAX + 1);
    localparam int BITW    = $clog2(WORD_W + 1);
    localparam int TMRW    = $clog2(DEADLINE + 1);
    localparam logic [DIVW-1:0] GAP_LAST  = DIVW'(START_GAP - 1);
    localparam logic [DIVW-1:0] HALF_LAST = DIVW'(HALF_DIV - 1);
    localparam logic [BITW-1:0] BIT_FULL  = BITW'(WORD_W);
    localparam logic [TMRW-1:0] TMR_LAST  = TMRW'(DEADLINE - 1);

    srd_state_e        state_q, state_d;
    logic [DIVW-1:0]   div_q;
    logic [BITW-1:0]   bit_q;
    logic [TMRW-1:0]   tmr_q;
    logic              line_s, rdy_evt, listen, shift_en, step, skip;
    logic [WORD_W-1:0] shreg;
    logic              sclk_q, valid_q, late_q;

    assign listen   = (state_q == ST_IDLE);
    assign shift_en = (state_q == ST_CLK_LO) && (state_d == ST_CLK_HI);
    assign step     = (state_q == ST_FINISH) || (state_q == ST_EXPIRE);

    srd_line_front #(.SYNC_STAGES(SYNC_STAGES), .HI_MIN(HI_MIN)) u_front (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .listen(listen),
        .line_s(line_s), .rdy_evt(rdy_evt)
    );

    srd_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear(rdy_evt), .shift_en(shift_en),
        .bit_in(line_s), .word(shreg)
    );

    srd_chan_step #(.CHAN_W(CHAN_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .step(step), .scan_en(scan_en),
        .chan_in(chan_in), .chsel(chsel), .skip(skip)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (rdy_evt) state_d = ST_GAP;
            ST_GAP:    if (div_q == GAP_LAST) state_d = ST_CLK_LO;
            ST_CLK_LO: if (div_q == HALF_LAST) state_d = ST_CLK_HI;
            ST_CLK_HI: if (div_q == HALF_LAST)
                           state_d = (bit_q == BIT_FULL) ? ST_FINISH : ST_CLK_LO;
            ST_FINISH: state_d = ST_IDLE;
            ST_EXPIRE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if ((state_q == ST_GAP || state_q == ST_CLK_LO || state_q == ST_CLK_HI)
            && tmr_q == TMR_LAST) begin
            state_d = ST_EXPIRE;
        end
    end

    // State register with its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            div_q   <= '0;
            bit_q   <= '0;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            div_q   <= (state_d != state_q) ? '0 : div_q + DIVW'(1);
            if (state_q == ST_IDLE)  bit_q <= '0;
            else if (shift_en)       bit_q <= bit_q + BITW'(1);
            tmr_q   <= (state_q == ST_IDLE) ? '0 : tmr_q + TMRW'(1);
        end
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            valid_q <= 1'b0;
            late_q  <= 1'b0;
        end else begin
            sclk_q  <= (state_d == ST_CLK_HI);
            valid_q <= (state_d == ST_FINISH || state_d == ST_EXPIRE) && !skip;
            late_q  <= (state_d == ST_EXPIRE) && !skip;
        end
    end

    assign sclk       = sclk_q;
    assign word_valid = valid_q;
    assign word_late  = late_q;
    assign word_data  = late_q ? '0 : shreg;
    assign word_chan  = chsel;

endmodule

// File: rtl/srd_reader_chk.sv
module srd_reader_chk #(
    parameter int WORD_W = 24,
    parameter int CHAN_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              word_valid,
    input logic              word_late,
    input logic [WORD_W-1:0] word_data,
    input logic [CHAN_W-1:0] chsel,
    input logic              scan_en,
    input logic              step,
    input logic              skip,
    input logic              rdy_evt
);
    localparam int RCW = $clog2(WORD_W + 2);

    logic           seen_q, sclk_prev;
    logic [RCW-1:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q    <= 1'b0;
            sclk_prev <= 1'b0;
            rise_cnt  <= '0;
        end else begin
            if (rdy_evt) seen_q <= 1'b1;
            sclk_prev <= sclk;
            if (step)                   rise_cnt <= '0;
            else if (sclk && !sclk_prev) rise_cnt <= rise_cnt + RCW'(1);
        end
    end

    p_clock_after_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && !sclk_prev) |-> seen_q);

    p_pulse_budget_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_cnt <= RCW'(WORD_W));

    p_idle_at_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !sclk);

    p_late_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_late) |-> (word_data == '0));

    p_scan_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && scan_en && !skip) |=> (chsel == $past(chsel) + CHAN_W'(1)));

    p_chan_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(chsel));

endmodule

bind srd_reader srd_reader_chk #(.WORD_W(WORD_W), .CHAN_W(CHAN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .word_valid(word_valid),
    .word_late(word_late), .word_data(word_data), .chsel(chsel),
    .scan_en(scan_en), .step(step), .skip(skip), .rdy_evt(rdy_evt)
);

// File: tb/tb_srd_reader.sv
`timescale 1ns/1ps
module tb_srd_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_in = 1'b0;
    logic        scan_en = 1'b0;
    logic [1:0]  chan_in = 2'd0;
    logic        sclk, valid, late;
    logic [1:0]  chsel, chan;
    logic [23:0] data;
    logic        t_sclk, t_valid, t_late;
    logic [1:0]  t_chsel, t_chan;
    logic [23:0] t_data;

    int n_chk = 0, n_fail = 0;
    int n_words = 0, rises = 0, t_cnt = 0, t_bad = 0;
    logic [23:0] got_data;
    logic [1:0]  got_chan;
    logic        got_late;

    always #2.5 clk = ~clk;

    srd_reader dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .scan_en(scan_en),
        .chan_in(chan_in), .sclk(sclk), .chsel(chsel), .word_valid(valid),
        .word_late(late), .word_data(data), .word_chan(chan)
    );

    srd_reader #(.DEADLINE(100)) dut_tight (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .scan_en(scan_en),
        .chan_in(chan_in), .sclk(t_sclk), .chsel(t_chsel), .word_valid(t_valid),
        .word_late(t_late), .word_data(t_data), .word_chan(t_chan)
    );

    always @(negedge clk) begin
        if (rst_n && valid) begin
            n_words++; got_data = data; got_chan = chan; got_late = late;
        end
        if (rst_n && t_valid) begin
            t_cnt++;
            if (!t_late || t_data != 24'd0) t_bad++;
        end
    end

    always @(posedge sclk) rises++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Converter model: high period, fall, MSB, then a new bit after each sclk fall.
    task automatic convert(input logic [23:0] w);
        line_in = 1'b1;
        repeat (12) @(posedge clk);
        #1 line_in = 1'b0;
        repeat (2) @(posedge clk);
        #1 line_in = w[23];
        for (int i = 22; i >= 0; i--) begin
            @(negedge sclk);
            #1 line_in = w[i];
        end
        @(negedge sclk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic read_expect(input logic [23:0] w, input logic [1:0] ch, input string req);
        int w0 = n_words, r0 = rises;
        convert(w);
        chk(n_words == w0 + 1, {req, " one strobe R5"}, n_words - w0, 1);
        chk(got_data == w, {req, " data R3 R4"}, got_data, w);
        chk(got_chan == ch, {req, " tag R7"}, got_chan, ch);
        chk(got_late == 1'b0, {req, " not late R5"}, got_late, 0);
        chk(rises - r0 == 24, {req, " pulses R2"}, rises - r0, 24);
    endtask

    task automatic read_drop(input logic [23:0] w, input string req);
        int w0 = n_words, r0 = rises;
        convert(w);
        chk(n_words == w0, {req, " dropped R10"}, n_words - w0, 0);
        chk(rises - r0 == 24, {req, " full clocking R10"}, rises - r0, 24);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(sclk == 1'b0, "R11 sclk", sclk, 0);
        chk(valid == 1'b0, "R11 valid", valid, 0);
        chk(late == 1'b0, "R11 late", late, 0);
        chk(chsel == 2'd0, "R11 chsel", chsel, 0);
    endtask

    task automatic t_no_early();
        repeat (30) @(posedge clk);
        #1 line_in = 1'b1;
        repeat (5) @(posedge clk);
        #1 line_in = 1'b0;
        repeat (30) @(posedge clk);
        chk(rises == 0, "R1 no clock before qualified ready", rises, 0);
        chk(n_words == 0, "R1 no strobe before qualified ready", n_words, 0);
    endtask

    task automatic t_codes();
        read_expect(24'h7FFFFF, 2'd0, "R4 +full");
        read_expect(24'h000000, 2'd0, "R4 zero");
        read_expect(24'h800000, 2'd0, "R4 -full");
        read_expect(24'hA5C3F1, 2'd0, "R3 pattern");
        chk(sclk == 1'b0, "R2 idle low", sclk, 0);
    endtask

    task automatic t_scan();
        scan_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            read_expect(24'h123456 + 24'(k), 2'(k), "R8 scan");
            chk(chsel == 2'(k + 1), "R8 advance", chsel, 2'(k + 1));
            read_drop(24'h654321, "R10 scan");
            chk(chsel == 2'(k + 1), "R8 hold on drop", chsel, 2'(k + 1));
        end
        scan_en = 1'b0;
    endtask

    task automatic t_fixed();
        read_expect(24'h0F0F0F, 2'd0, "R9 steady");
        chk(chsel == 2'd0, "R9 unchanged", chsel, 0);
        chan_in = 2'd2;
        repeat (20) @(posedge clk);
        chk(chsel == 2'd0, "R9 waits for read end", chsel, 0);
        read_expect(24'hF0F0F0, 2'd0, "R9 old channel");
        chk(chsel == 2'd2, "R9 follows chan_in", chsel, 2);
        read_drop(24'h333333, "R10 fixed");
        read_expect(24'hC00001, 2'd2, "R9 new channel");
    endtask

    task automatic t_deadline();
        int c0 = t_cnt;
        read_expect(24'h400000, 2'd2, "R6 relaxed");
        chk(t_cnt > c0, "R6 tight read flagged", t_cnt - c0, 1);
        chk(t_bad == 0, "R6 late word zero", t_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_no_early();
        t_codes();
        t_scan();
        t_fixed();
        t_deadline();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule